// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits over several clock cycles. It uses radix-2 Booth recoding. A start pulse loads the multiplicand into a holding register and the multiplier into a shift register. It also clears the accumulator and the extra low bit that sits below the multiplier. Each following cycle looks at the two lowest bits of the multiplier chain, the current bit and the bit just shifted out. From that pair the cycle subtracts the multiplicand from the accumulator, adds it, or leaves the accumulator alone. It then shifts accumulator, multiplier and extra bit one place to the right as a single arithmetic word.

After exactly `WIDTH` such steps the accumulator and multiplier together hold the signed product of width `2*WIDTH`. The block raises `done` for one cycle and keeps the product on its output until the next accepted start. A caller pulses `start` while the unit is idle, waits for `done`, and then reads `product`. The accumulator carries one guard bit above `WIDTH`, so that even the most negative multiplicand gives an exact result.

Top module: `booth_mult`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` pulse seen while the unit is idle loads both operands and makes `busy` 1 in the next cycle.
- R3: A step whose bit pair (current multiplier bit, previously shifted-out bit) is 1,0 subtracts the multiplicand from the accumulator before the shift. A multiplier of all ones gives the negated multiplicand.
- R4: A step whose bit pair is 0,1 adds the multiplicand to the accumulator before the shift. This happens, for example, with 7 times 3 giving 21.
- R5: A step whose bit pair is 0,0 or 1,1 only shifts. A multiplier of 0 gives a product of 0.
- R6: `busy` stays 1 for exactly `WIDTH` cycles, one per add/subtract-and-shift step, and `done` follows in the next cycle.
- R7: `done` is a pulse exactly one cycle long, and `busy` and `done` are never 1 together.
- R8: `product` at `done` equals the signed product of the two operands for every sign combination, as a `2*WIDTH`-bit two's-complement value. For example, -7 times 3 gives 8'b1110_1011 and -7 times -3 gives 8'b0001_0101.
- R9: The most negative operand value gives the exact product with no saturation. For example, -8 times -8 gives 64 and -8 times 1 gives -8.
- R10: `start` is ignored while `busy` or `done` is 1. The running multiplication finishes with its original operands and completes at the expected time.
- R11: Once `done` has been seen, `product` stays unchanged until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; only honoured when idle |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | High during the add/subtract-and-shift steps |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed product, the accumulator and multiplier registers concatenated |

## Verification
The assertions check the handshake on every cycle:
- An accepted start leads to `busy`.
- `busy` lasts exactly `WIDTH` cycles before `done`, counted by the checker.
- `done` is a single-cycle pulse and is never high together with `busy`.
- `product` stays unchanged while the unit is idle.

Only the bench's scenarios can show the arithmetic: the subtract, add and skip steps, the full 256-pair operand sweep across all sign combinations, and the most-negative cases. The same applies to the fact that a start arriving mid-run or on the done cycle leaves the result unchanged.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        OP_KEEP = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } op_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic q_lsb,
    input  logic q_prev,
    output op_e  op
);
    always_comb begin
        unique case ({q_lsb, q_prev})
            2'b10:   op = OP_SUB;
            2'b01:   op = OP_ADD;
            default: op = OP_KEEP;
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] acc,
    input  logic [AW-1:0] mcand_ext,
    input  op_e           op,
    output logic [AW-1:0] result
);
    always_comb begin
        unique case (op)
            OP_ADD:  result = acc + mcand_ext;
            OP_SUB:  result = acc - mcand_ext;
            default: result = acc;
        endcase
    end
endmodule

// File: rtl/booth_ashr.sv
module booth_ashr #(
    parameter int AW = 5,
    parameter int QW = 4
) (
    input  logic [AW-1:0] acc_in,
    input  logic [QW-1:0] q_in,
    output logic [AW-1:0] acc_out,
    output logic [QW-1:0] q_out,
    output logic          q_prev_out
);
    always_comb begin
        acc_out    = {acc_in[AW-1], acc_in[AW-1:1]};
        q_out      = {acc_in[0], q_in[QW-1:1]};
        q_prev_out = q_in[0];
    end
endmodule

// File: rtl/booth_mult.sv
module booth_mult
    import booth_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    localparam int AW = WIDTH + 1;
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    typedef struct packed {
        state_e          st;
        logic [AW-1:0]   acc;
        logic [WIDTH-1:0] q;
        logic            q_prev;
        logic [WIDTH-1:0] m;
        logic [CW-1:0]   step;
    } regs_t;

    regs_t r_q, r_d;

    op_e             step_op;
    logic [AW-1:0]   acc_mod;
    logic [AW-1:0]   acc_sh;
    logic [WIDTH-1:0] q_sh;
    logic            q_prev_sh;

    booth_recode u_recode (
        .q_lsb  (r_q.q[0]),
        .q_prev (r_q.q_prev),
        .op     (step_op)
    );

    booth_addsub #(.AW(AW)) u_addsub (
        .acc       (r_q.acc),
        .mcand_ext ({r_q.m[WIDTH-1], r_q.m}),
        .op        (step_op),
        .result    (acc_mod)
    );

    booth_ashr #(.AW(AW), .QW(WIDTH)) u_ashr (
        .acc_in     (acc_mod),
        .q_in       (r_q.q),
        .acc_out    (acc_sh),
        .q_out      (q_sh),
        .q_prev_out (q_prev_sh)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st     = ST_RUN;
                    r_d.acc    = '0;
                    r_d.q      = mplier;
                    r_d.q_prev = 1'b0;
                    r_d.m      = mcand;
                    r_d.step   = '0;
                end
            end
            ST_RUN: begin
                r_d.acc    = acc_sh;
                r_d.q      = q_sh;
                r_d.q_prev = q_prev_sh;
                r_d.step   = r_q.step + 1'b1;
                if (r_q.step == LAST_STEP) begin
                    r_d.st = ST_DONE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st == ST_RUN);
    assign done    = (r_q.st == ST_DONE);
    assign product = {r_q.acc[WIDTH-1:0], r_q.q};

endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
    parameter int WIDTH = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);
    localparam int KW = $clog2(WIDTH + 2) + 1;

    logic [KW-1:0] run_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len_q <= '0;
        end else if (done) begin
            run_len_q <= '0;
        end else if (busy) begin
            run_len_q <= run_len_q + 1'b1;
        end
    end

    AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy); // R2

    AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len_q == KW'(WIDTH))); // R6

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len_q < KW'(WIDTH))); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R7

    AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start && !done)) |=> $stable(product)); // R11

endmodule

bind booth_mult booth_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/tb_booth_mult.sv
module tb_booth_mult;
    localparam int W  = 4;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  mcand = '0;
    logic [W-1:0]  mplier = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int checks = 0;
    int errors = 0;
    logic [PW-1:0] exp_q[$];
    string         tag_q[$];

    always #5 clk = ~clk;

    booth_mult #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .product(product)
    );

    task automatic check(input bit ok, input string req,
                         input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic signed [PW-1:0] ea;
        logic signed [PW-1:0] eb;
        ea = $signed(a);
        eb = $signed(b);
        return ea * eb;
    endfunction

    // monitor: pops expected product at each done
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected done", product, '0);
            end else begin
                automatic logic [PW-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(product == e, t, product, e);
            end
        end
    end

    // driver; poke = 1 sends stray starts mid-run and on the done cycle
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                           input string tag, input bit poke);
        int cycles;
        logic [PW-1:0] e;
        while (busy || done) @(negedge clk);
        e = ref_mul(a, b);
        mcand = a; mplier = b; start = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", PW'(busy), PW'(1));
        cycles = 0;
        while (!done) begin
            if (busy) cycles++;
            if (poke && cycles == 2) begin
                mcand = ~a; mplier = ~b; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        check(cycles == W, "R6 busy length", PW'(cycles), PW'(W));
        if (poke) begin
            mcand = a + 1'b1; mplier = b + 1'b1; start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R7 done one cycle", PW'(done), PW'(0));
        if (poke) begin
            check(busy == 1'b0, "R10 start on done ignored", PW'(busy), PW'(0));
            @(negedge clk);
            @(negedge clk);
            check(product == e && !busy, "R11 product held", product, e);
            check(product == e, "R10 result kept", product, e);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 reset flags", {busy, done}, '0);
        check(product == '0, "R1 reset product", product, '0);

        run_mul(4'sd7,  4'sd3,  "R4 7x3", 1'b0);
        run_mul(4'sd7, -4'sd3,  "R8 7x-3", 1'b0);
        run_mul(-4'sd7, 4'sd3,  "R8 -7x3", 1'b0);
        run_mul(-4'sd7, -4'sd3, "R8 -7x-3", 1'b0);
        run_mul(4'sd5,  4'b1111, "R3 5x-1", 1'b0);
        run_mul(4'sd6,  4'sd0,  "R5 6x0", 1'b0);
        run_mul(4'b1000, 4'b1000, "R9 -8x-8", 1'b0);
        run_mul(4'b1000, 4'sd1, "R9 -8x1", 1'b0);
        run_mul(4'sd1, 4'b1000, "R9 1x-8", 1'b0);
        run_mul(4'sd7, 4'b1000, "R9 7x-8", 1'b0);
        run_mul(-4'sd5, 4'sd6,  "R10 poke -5x6", 1'b1);

        for (int i = 0; i < (1 << W); i++) begin
            for (int j = 0; j < (1 << W); j++) begin
                run_mul(W'(i), W'(j), "R8 sweep", 1'b0);
            end
        end

        while (busy || done) @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R8 all results seen", PW'(exp_q.size()), '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule